// File: doc/BRIEF.md
# Byte-Addressed Register Port over I2C

This block is a target-side I2C controller that gives a bus host access to a small register bank. It watches SCL and SDA with an oversampling system clock, recognises start, repeated start and stop, answers to one seven-bit device address, and pulls SDA low through an open-drain enable when it has to acknowledge or send a zero. It never touches SCL.

The first byte written after the device address loads an eight-bit position pointer. Each later byte either writes to the bank at the pointer or, in a read transfer, is fetched from the bank at the pointer. The pointer then steps by one and wraps past its highest value. Positions the bank does not implement are refused with NACK on writes and read back as zero. The pointer still steps over them, so a long transfer can run across gaps and past the wrap.

The bank side is a plain combinational read port addressed by the pointer, together with a one-cycle write strobe carrying data. The write path has no ready signal, because without clock stretching the bus cannot be held: the bank must take every strobe in the cycle it is given. The block also reports whether the pointer currently selects an implemented position.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges a device address byte whose upper six bits are 101011 and whose bit 0 equals `addr_sel`, so the address is 56h with `addr_sel` low and 57h with it high. The direction bit is 1 for a read. Any other address leaves SDA released for the whole transfer.
- R2: In a write transfer, the first byte after the address loads the pointer. It is acknowledged only when the new value is an implemented position. The implemented positions are 00h to 07h and 0Bh.
- R3: The pointer is eight bits wide. It steps by one after every data byte, whether that byte is written or read and whether the position is implemented or not. It wraps from FFh to 00h.
- R4: A data byte written to an implemented position is acknowledged. It produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. A byte written to any other position is answered with NACK and produces no pulse.
- R5: Read bytes go out MSB first. They carry `reg_rdata` for implemented positions and 00h for all others.
- R6: A read transfer that has no pointer write in front of it starts at the pointer value left by the previous transfer.
- R7: After the host answers a read byte with NACK, the block releases SDA and sends nothing further. A stop returns the block to idle.
- R8: A start or repeated start during a byte abandons that byte without changing the pointer. The block then waits for a new device address.
- R9: The SDA enable changes only while the synchronised SCL is low.
- R10: After reset SDA is released, no write strobe is active and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL line level |
| sda_i | input | 1 | Filtered SDA line level |
| addr_sel | input | 1 | Strap choosing bit 0 of the device address |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Current pointer, used as bank address |
| reg_addr_ok | output | 1 | Pointer selects an implemented position |
| reg_rdata | input | 8 | Bank read data at `reg_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data accompanying the strobe |

## Verification
The bench builds the block with its default parameters: address prefix 101011, eight low positions, 0Bh as the extra position and a two-stage synchroniser. A quarter SCL period of six system clocks leaves room for the synchroniser and edge-detect latency. With these values the gap at 08h to 0Ah and the wrap from FFh to 00h can be reached by short transfers, so directed writes and reads cover refused writes, zero reads and crossing the wrap. Both strap values are exercised, and a byte is abandoned part-way by a repeated start.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_TX
  } bus_st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_WDATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  // R8: start and stop can never be seen in the same cycle
  a_r8_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_pos_decode.sv
module i2c_pos_decode #(
  parameter int          NUM_LOW   = 8,
  parameter logic [7:0]  EXTRA_POS = 8'h0B
) (
  input  logic [7:0] pos,
  output logic       ok
);
  localparam logic [8:0] LOW_LIM = 9'(NUM_LOW);

  assign ok = ({1'b0, pos} < LOW_LIM) || (pos == EXTRA_POS);
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b101011,
  parameter int         NUM_LOW     = 8,
  parameter logic [7:0] EXTRA_POS   = 8'h0B,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_addr_ok,
  input  logic [7:0] reg_rdata,
  output logic       reg_wr_en,
  output logic [7:0] reg_wdata
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ACK_DRV  = 4'(BYTE_W);
  localparam logic [3:0] ACK_CLK  = 4'(BYTE_W + 1);
  localparam logic [3:0] ACK_DONE = 4'(BYTE_W + 2);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_st_e      state;
  rx_kind_e     kind;
  logic [3:0]   cnt;
  logic [6:0]   sh;
  logic         rw_q, ack_q, sda_oe_q, wr_en_q;
  logic [7:0]   ptr, txd, wdata_q;
  logic [7:0]   rx_byte, rd_byte;
  logic         ptr_ok, byte_ok;

  assign rx_byte = {sh, sda_s};

  i2c_pos_decode #(.NUM_LOW(NUM_LOW), .EXTRA_POS(EXTRA_POS)) u_dec_ptr (
    .pos (ptr),
    .ok  (ptr_ok)
  );

  i2c_pos_decode #(.NUM_LOW(NUM_LOW), .EXTRA_POS(EXTRA_POS)) u_dec_rx (
    .pos (rx_byte),
    .ok  (byte_ok)
  );

  assign rd_byte = ptr_ok ? reg_rdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      sh       <= '0;
      rw_q     <= 1'b0;
      ack_q    <= 1'b0;
      sda_oe_q <= 1'b0;
      wr_en_q  <= 1'b0;
      ptr      <= '0;
      txd      <= '0;
      wdata_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        kind     <= K_ADDR;
        cnt      <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt < ACK_DRV) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 4'd1;
              if (cnt == LAST_BIT) begin
                unique case (kind)
                  K_ADDR: begin
                    if (sh == {ADDR_PREFIX, addr_sel}) begin
                      rw_q  <= sda_s;
                      ack_q <= 1'b1;
                    end else begin
                      state <= ST_IDLE;
                    end
                  end
                  K_PTR: begin
                    ptr   <= rx_byte;
                    ack_q <= byte_ok;
                  end
                  default: begin
                    ack_q <= ptr_ok;
                    if (ptr_ok) begin
                      wr_en_q <= 1'b1;
                      wdata_q <= rx_byte;
                    end
                  end
                endcase
              end
            end else if (scl_fall && cnt == ACK_DRV) begin
              sda_oe_q <= ack_q;
              cnt      <= ACK_CLK;
            end else if (scl_fall && cnt == ACK_CLK) begin
              cnt <= '0;
              unique case (kind)
                K_ADDR: begin
                  if (rw_q) begin
                    state    <= ST_TX;
                    txd      <= rd_byte;
                    sda_oe_q <= ~rd_byte[7];
                    ptr      <= ptr + 8'd1;
                  end else begin
                    kind     <= K_PTR;
                    sda_oe_q <= 1'b0;
                  end
                end
                K_PTR: begin
                  kind     <= K_WDATA;
                  sda_oe_q <= 1'b0;
                end
                default: begin
                  ptr      <= ptr + 8'd1;
                  sda_oe_q <= 1'b0;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise && cnt < ACK_DRV) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt != 4'd0 && cnt < ACK_DRV) begin
              sda_oe_q <= ~txd[6];
              txd      <= {txd[6:0], 1'b0};
            end else if (scl_fall && cnt == ACK_DRV) begin
              sda_oe_q <= 1'b0;
              cnt      <= ACK_CLK;
            end else if (scl_rise && cnt == ACK_CLK) begin
              if (sda_s) state <= ST_IDLE;
              else       cnt   <= ACK_DONE;
            end else if (scl_fall && cnt == ACK_DONE) begin
              txd      <= rd_byte;
              sda_oe_q <= ~rd_byte[7];
              ptr      <= ptr + 8'd1;
              cnt      <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe      = sda_oe_q;
  assign reg_addr    = ptr;
  assign reg_addr_ok = ptr_ok;
  assign reg_wr_en   = wr_en_q;
  assign reg_wdata   = wdata_q;

  // R9: the open-drain enable only moves while SCL is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !scl_s);

  // R4: a strobe only ever targets an implemented position
  a_r4_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_addr_ok);

  // R4: each strobe lasts one cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R7: stop leaves the block idle with SDA released
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_q));

  // R8: a start always leads to address reception from bit zero
  a_r8_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX && kind == K_ADDR && cnt == 4'd0));

  // R8: a start leaves the pointer untouched
  a_r8_start_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(ptr));
endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int CLK_NS = 10;
  localparam int Q      = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe, reg_addr_ok, reg_wr_en;
  logic [7:0] reg_addr, reg_rdata, reg_wdata;
  logic       sda_line;
  logic [7:0] mem [0:255];
  int         wr_cnt = 0;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regslave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_sel    (addr_sel),
    .sda_oe      (sda_oe),
    .reg_addr    (reg_addr),
    .reg_addr_ok (reg_addr_ok),
    .reg_rdata   (reg_rdata),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata)
  );

  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick();
    scl_m = 1'b1; tick(); tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    b = sda_line; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(x);
    acked = ~x;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      v[i] = x;
    end
    bit_out(last);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    chk("R10 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R10 wr_en", {7'd0, reg_wr_en}, 8'h00);
    chk("R10 pointer", reg_addr, 8'h00);
    bus_start(); wr_byte(8'hAD, a);
    rd_byte(1'b1, d);
    chk("R10 first read at 00", d, 8'h5A);
    bus_stop();
  endtask

  task automatic t_addr();
    logic a;
    bus_start(); wr_byte(8'hAE, a); bus_stop();
    chk("R1 57h refused with strap low", {7'd0, a}, 8'h00);
    bus_start(); wr_byte(8'hAC, a); bus_stop();
    chk("R1 56h ack with strap low", {7'd0, a}, 8'h01);
    addr_sel = 1'b1; tick();
    bus_start(); wr_byte(8'hAE, a); bus_stop();
    chk("R1 57h ack with strap high", {7'd0, a}, 8'h01);
    bus_start(); wr_byte(8'hAC, a); bus_stop();
    chk("R1 56h refused with strap high", {7'd0, a}, 8'h00);
    addr_sel = 1'b0; tick();
  endtask

  task automatic t_ptr();
    logic a;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h05, a); bus_stop();
    chk("R2 ptr 05 ack", {7'd0, a}, 8'h01);
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h09, a); bus_stop();
    chk("R2 ptr 09 nack", {7'd0, a}, 8'h00);
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h0B, a); bus_stop();
    chk("R2 ptr 0B ack", {7'd0, a}, 8'h01);
    chk("R2 ptr loaded", reg_addr, 8'h0B);
  endtask

  task automatic t_page_write();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h02, a);
    wr_byte(8'h11, a); chk("R4 ack 02", {7'd0, a}, 8'h01);
    wr_byte(8'h22, a); chk("R4 ack 03", {7'd0, a}, 8'h01);
    wr_byte(8'h33, a); chk("R4 ack 04", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R4 mem02", mem[2], 8'h11);
    chk("R4 mem03", mem[3], 8'h22);
    chk("R4 mem04", mem[4], 8'h33);
    chk("R4 strobe count", 8'(wr_cnt - w0), 8'd3);
    chk("R3 ptr after page", reg_addr, 8'h05);
  endtask

  task automatic t_gap_write();
    logic a; int w0;
    w0 = wr_cnt;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h07, a);
    wr_byte(8'h71, a); chk("R4 ack 07", {7'd0, a}, 8'h01);
    wr_byte(8'h81, a); chk("R4 nack 08", {7'd0, a}, 8'h00);
    wr_byte(8'h91, a); chk("R4 nack 09", {7'd0, a}, 8'h00);
    wr_byte(8'hA1, a); chk("R4 nack 0A", {7'd0, a}, 8'h00);
    wr_byte(8'hB1, a); chk("R3 ack again at 0B", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R4 mem08 kept", mem[8], 8'h52);
    chk("R4 mem0B", mem[11], 8'hB1);
    chk("R4 gap strobes", 8'(wr_cnt - w0), 8'd2);
  endtask

  task automatic t_seq_read();
    logic a; logic [7:0] d;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h02, a);
    bus_start(); wr_byte(8'hAD, a);
    chk("R5 read addr ack", {7'd0, a}, 8'h01);
    rd_byte(1'b0, d); chk("R5 read 02", d, 8'h11);
    rd_byte(1'b0, d); chk("R5 read 03", d, 8'h22);
    rd_byte(1'b1, d); chk("R5 read 04", d, 8'h33);
    chk("R7 released after nack", {7'd0, sda_line}, 8'h01);
    bus_stop();
    bus_start(); wr_byte(8'hAD, a);
    rd_byte(1'b1, d);
    chk("R6 current read at 05", d, 8'h5F);
    bus_stop();
  endtask

  task automatic t_invalid_read();
    logic a; logic [7:0] d;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'h06, a);
    bus_start(); wr_byte(8'hAD, a);
    rd_byte(1'b0, d); chk("R5 read 06", d, 8'h5C);
    rd_byte(1'b0, d); chk("R5 read 07", d, 8'h71);
    rd_byte(1'b0, d); chk("R5 read 08 zero", d, 8'h00);
    rd_byte(1'b0, d); chk("R5 read 09 zero", d, 8'h00);
    rd_byte(1'b0, d); chk("R5 read 0A zero", d, 8'h00);
    rd_byte(1'b1, d); chk("R5 read 0B", d, 8'hB1);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'hFE, a);
    chk("R2 ptr FE nack", {7'd0, a}, 8'h00);
    wr_byte(8'hC0, a); chk("R3 nack FE", {7'd0, a}, 8'h00);
    wr_byte(8'hC1, a); chk("R3 nack FF", {7'd0, a}, 8'h00);
    wr_byte(8'hC2, a); chk("R3 ack after wrap", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R3 mem00 after wrap", mem[0], 8'hC2);
    bus_start(); wr_byte(8'hAC, a); wr_byte(8'hFF, a);
    bus_start(); wr_byte(8'hAD, a);
    rd_byte(1'b0, d); chk("R5 read FF zero", d, 8'h00);
    rd_byte(1'b1, d); chk("R5 read wraps to 00", d, 8'hC2);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d;
    bus_start(); wr_byte(8'hAC, a);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    bus_start(); wr_byte(8'hAD, a);
    chk("R8 address after abort", {7'd0, a}, 8'h01);
    rd_byte(1'b1, d);
    chk("R8 pointer kept", d, 8'h5B);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_addr();
    t_ptr();
    t_page_write();
    t_gap_write();
    t_seq_read();
    t_invalid_read();
    t_wrap();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule